// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register side of a general-purpose I/O controller. Each pin property has a bank of consecutive 32-bit words: direction, output data, four groups of interrupt enables, interrupt polarity, interrupt type and interrupt status. Each word of a bank covers 32 pins. The address space is sized for 96 pins, but only the lowest `NUM_PINS` (70 by default) exist. Software reaches the banks through a simple request port. The block drives per-pin output-enable and output-value lines. It resynchronizes the pin inputs and hands the interrupt configuration and the synchronized levels to a separate edge/level detector, which reports events back as set pulses.

The request port takes one request per cycle and has no back-pressure: every request with `req_valid` high is accepted in that cycle, and its response appears on the next cycle with `rsp_valid` high. The consumer of the response must always take it, because the block never holds a response. The detector interface and the pin lines are plain level signals.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every stored bit is zero, so `pin_oe`, `pin_out`, `irq_en`, `irq_pol`, `irq_type` and `irq_stat` are all zero, and `rsp_valid` is low.
- R2: A request accepted on a clock edge produces `rsp_valid` high in the following cycle only. For a read, `rsp_rdata` holds the addressed word as it was at the request edge. For a write, `rsp_rdata` is zero.
- R3: Pin n is bit n%32 of the word at byte address base + 4*(n/32). The bank bases are: direction 0x014, output data 0x024, interrupt enable groups 0x044, 0x054, 0x064 and 0x074, polarity 0x104, type 0x114, status 0x124. Each bank has three words.
- R4: A direction bit of 1 drives `pin_oe` high for that pin (output) and 0 makes it an input. Direction words read back as written.
- R5: A write to the output data bank sets `pin_out`. A read of that bank returns the synchronized pin levels (`pin_sync`), not the written values.
- R6: All four interrupt enable groups store and read back their words. Only the group at 0x044 drives `irq_en`.
- R7: Polarity and type words store, read back and drive `irq_pol` and `irq_type` directly.
- R8: A status bit is set by a high `irq_stat_set` bit and cleared by writing 1 to it; writing 0 leaves it unchanged. When a set and a clear hit the same bit in the same cycle, the set wins.
- R9: Bits for pins at or above `NUM_PINS` (pins 70 to 95) read as zero and ignore writes.
- R10: Addresses outside the banks read as zero and writes to them change nothing. This covers 0x000 to 0x010, the fourth word slot of each 0x10 stride, and any address with nonzero low two bits.
- R11: `pin_sync` equals `pin_in` delayed by exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output value |
| pin_sync | output | NUM_PINS | Synchronized pin levels to the detector |
| irq_en | output | NUM_PINS | Interrupt enables (group 0) |
| irq_pol | output | NUM_PINS | Interrupt polarity, 1 = low/falling |
| irq_type | output | NUM_PINS | Interrupt type, 1 = edge |
| irq_stat_set | input | NUM_PINS | Event pulses from the detector |
| irq_stat | output | NUM_PINS | Pending interrupt status |

## Verification
A wrong bank decode or a wrong word index shows up on the next response as data in the wrong word or bit. It also shows at once on `pin_oe`, `pin_out` or the interrupt outputs, one edge after the write. A fault in the status logic, such as a lost set, a clear applied with 0 or a clear that beats a set, shows up on `irq_stat` one edge later and on the next status read. A synchronizer that has the wrong depth shows on `pin_sync` within two edges of a change on `pin_in`.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W     = 32;
  localparam int IEN_GROUPS = 4;

  typedef enum logic [3:0] {
    FEAT_NONE  = 4'd0,
    FEAT_DIR   = 4'd1,
    FEAT_LEVEL = 4'd2,
    FEAT_IEN0  = 4'd3,
    FEAT_IEN1  = 4'd4,
    FEAT_IEN2  = 4'd5,
    FEAT_IEN3  = 4'd6,
    FEAT_IPOL  = 4'd7,
    FEAT_ITYPE = 4'd8,
    FEAT_ISTAT = 4'd9
  } feat_e;

  localparam int NUM_FEATS = 10;

  // byte offset of word 0 of each bank
  function automatic int feat_base(input feat_e f);
    case (f)
      FEAT_DIR:   return 'h014;
      FEAT_LEVEL: return 'h024;
      FEAT_IEN0:  return 'h044;
      FEAT_IEN1:  return 'h054;
      FEAT_IEN2:  return 'h064;
      FEAT_IEN3:  return 'h074;
      FEAT_IPOL:  return 'h104;
      FEAT_ITYPE: return 'h114;
      FEAT_ISTAT: return 'h124;
      default:    return -1;
    endcase
  endfunction

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BANK_WORDS = 3,
  parameter int WIDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output feat_e             feat,
  output logic [WIDX_W-1:0] word
);

  localparam int BANK_BYTES = 4 * BANK_WORDS;

  always_comb begin
    int a;
    int b;
    feat = FEAT_NONE;
    word = '0;
    a    = int'(32'(addr));
    for (int f = 1; f < NUM_FEATS; f++) begin
      b = feat_base(feat_e'(f[3:0]));
      if (addr[1:0] == 2'b00 && a >= b && a < b + BANK_BYTES) begin
        feat = feat_e'(f[3:0]);
        word = WIDX_W'((a - b) / 4);
      end
    end
  end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
  parameter int NUM_PINS = 70,
  parameter int WORD_W   = 32,
  parameter int WIDX_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WIDX_W-1:0]   wr_word,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] bits
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_word == WIDX_W'(p / WORD_W)) bits[p] <= wr_data[p % WORD_W];
      end
    end
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NUM_PINS = 70,
  parameter int WORD_W   = 32,
  parameter int WIDX_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_in,
  input  logic                clr_en,
  input  logic [WIDX_W-1:0]   clr_word,
  input  logic [WORD_W-1:0]   clr_data,
  output logic [NUM_PINS-1:0] stat
);

  logic [NUM_PINS-1:0] clr_mask;

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int W = p / WORD_W;
      localparam int B = p % WORD_W;
      assign clr_mask[p] = clr_en && (clr_word == WIDX_W'(W)) && clr_data[B];
    end
  endgenerate

  // a new event outranks a clear landing in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= set_in | (stat & ~clr_mask);
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 70,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 70,
  parameter int MAX_PINS    = 96,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_sync,
  output logic [NUM_PINS-1:0] irq_en,
  output logic [NUM_PINS-1:0] irq_pol,
  output logic [NUM_PINS-1:0] irq_type,
  input  logic [NUM_PINS-1:0] irq_stat_set,
  output logic [NUM_PINS-1:0] irq_stat
);

  localparam int BANK_WORDS = (MAX_PINS + WORD_W - 1) / WORD_W;
  localparam int WIDX_W     = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1;
  localparam int FULL_W     = BANK_WORDS * WORD_W;

  feat_e               dec_feat;
  logic [WIDX_W-1:0]   dec_word;
  logic                wr_req;
  logic [NUM_PINS-1:0] ien_q [IEN_GROUPS];
  logic [FULL_W-1:0]   sel_full;
  logic [WORD_W-1:0]   rd_word;

  assign wr_req = req_valid && req_write;

  gpio_reg_decode #(
    .ADDR_W(ADDR_W), .BANK_WORDS(BANK_WORDS), .WIDX_W(WIDX_W)
  ) u_dec (
    .addr(req_addr), .feat(dec_feat), .word(dec_word)
  );

  gpio_in_sync #(
    .WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
  );

  gpio_cfg_bank #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_req && dec_feat == FEAT_DIR),
    .wr_word(dec_word), .wr_data(req_wdata), .bits(pin_oe)
  );

  gpio_cfg_bank #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_level (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_req && dec_feat == FEAT_LEVEL),
    .wr_word(dec_word), .wr_data(req_wdata), .bits(pin_out)
  );

  gpio_cfg_bank #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_ipol (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_req && dec_feat == FEAT_IPOL),
    .wr_word(dec_word), .wr_data(req_wdata), .bits(irq_pol)
  );

  gpio_cfg_bank #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_itype (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_req && dec_feat == FEAT_ITYPE),
    .wr_word(dec_word), .wr_data(req_wdata), .bits(irq_type)
  );

  genvar g;
  generate
    for (g = 0; g < IEN_GROUPS; g++) begin : g_ien
      gpio_cfg_bank #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_ien (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_req && int'(dec_feat) == int'(FEAT_IEN0) + g),
        .wr_word(dec_word), .wr_data(req_wdata), .bits(ien_q[g])
      );
    end
  endgenerate

  assign irq_en = ien_q[0];

  gpio_irq_status #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .WIDX_W(WIDX_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_in(irq_stat_set),
    .clr_en(wr_req && dec_feat == FEAT_ISTAT),
    .clr_word(dec_word), .clr_data(req_wdata), .stat(irq_stat)
  );

  // read path: widen the addressed bank to whole words, unbuilt pins stay 0
  always_comb begin
    sel_full = '0;
    case (dec_feat)
      FEAT_DIR:   sel_full[NUM_PINS-1:0] = pin_oe;
      FEAT_LEVEL: sel_full[NUM_PINS-1:0] = pin_sync;
      FEAT_IEN0:  sel_full[NUM_PINS-1:0] = ien_q[0];
      FEAT_IEN1:  sel_full[NUM_PINS-1:0] = ien_q[1];
      FEAT_IEN2:  sel_full[NUM_PINS-1:0] = ien_q[2];
      FEAT_IEN3:  sel_full[NUM_PINS-1:0] = ien_q[3];
      FEAT_IPOL:  sel_full[NUM_PINS-1:0] = irq_pol;
      FEAT_ITYPE: sel_full[NUM_PINS-1:0] = irq_type;
      FEAT_ISTAT: sel_full[NUM_PINS-1:0] = irq_stat;
      default:    sel_full = '0;
    endcase
    rd_word = sel_full[dec_word*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS = 70,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [31:0]         rsp_rdata,
  input logic                rsp_valid,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_sync,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] irq_stat_set,
  input logic [NUM_PINS-1:0] irq_stat
);

  logic [1:0] up_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)              up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 2'd0) |-> (rsp_valid == $past(req_valid)));

  // R2
  write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && up_cnt != 2'd0 && $past(req_write)) |-> (rsp_rdata == 32'd0));

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 2'd0 && !$past(req_valid && req_write)) |-> $stable(pin_oe));

  // R8
  stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 2'd0) |-> ((irq_stat & ~$past(irq_stat) & ~$past(irq_stat_set)) == '0));

  // R8
  stat_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 2'd0 && !$past(req_valid && req_write)) |-> ((~irq_stat & $past(irq_stat)) == '0));

  // R8
  stat_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 2'd0) |-> ((~irq_stat & $past(irq_stat_set)) == '0));

  // R11
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));

  // R10
  unaligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt != 2'd0 && $past(req_valid && req_addr[1:0] != 2'b00)) |-> (rsp_rdata == 32'd0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
  .pin_in(pin_in), .pin_sync(pin_sync), .pin_oe(pin_oe),
  .irq_stat_set(irq_stat_set), .irq_stat(irq_stat)
);

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;

  localparam int NP = 70;
  localparam int B [10] = '{0, 'h14, 'h24, 'h44, 'h54, 'h64, 'h74, 'h104, 'h114, 'h124};
  localparam logic [95:0] PMASK = {26'd0, {NP{1'b1}}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NP-1:0] pin_in = '0, pin_oe, pin_out, pin_sync;
  logic [NP-1:0] irq_en, irq_pol, irq_type, irq_stat_set = '0, irq_stat;

  int  errors = 0, checks = 0;
  bit  done = 0;
  logic [95:0] mdl [10];

  always #10 clk = ~clk;  // 50 MHz

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pin_sync(pin_sync), .irq_en(irq_en), .irq_pol(irq_pol), .irq_type(irq_type),
    .irq_stat_set(irq_stat_set), .irq_stat(irq_stat)
  );

  task automatic check(input string tag, input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int feat_of(input logic [11:0] a);
    for (int f = 1; f < 10; f++)
      if (a[1:0] == 2'b00 && int'(a) >= B[f] && int'(a) < B[f] + 12) return f;
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [NP-1:0] lvl);
    int f = feat_of(a);
    logic [95:0] v;
    if (f == 0) return 32'd0;
    v = (f == 2) ? {26'd0, lvl} : mdl[f];
    return v[((int'(a) - B[f]) / 4) * 32 +: 32];
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    int f = feat_of(a);
    logic [95:0] sh, wm;
    if (f == 0) return;
    sh = {64'd0, d} << (((int'(a) - B[f]) / 4) * 32);
    wm = {64'd0, 32'hffff_ffff} << (((int'(a) - B[f]) / 4) * 32);
    if (f == 9) mdl[9] = mdl[9] & ~sh;
    else        mdl[f] = (mdl[f] & ~wm) | (sh & wm & PMASK);
  endfunction

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] q, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    q = rsp_rdata; v = rsp_valid;
  endtask

  task automatic wr_chk(input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [31:0] q; logic v;
    xfer(1'b1, a, d, q, v);
    model_write(a, d);
    check({tag, " R2 write rsp"}, {63'd0, v, q}, {63'd0, 1'b1, 32'd0});
  endtask

  task automatic rd_chk(input logic [11:0] a, input string tag);
    logic [31:0] q; logic v;
    xfer(1'b0, a, 32'd0, q, v);
    check({tag, $sformatf(" read %h", a)}, {63'd0, v, q}, {63'd0, 1'b1, exp_read(a, pin_in)});
  endtask

  task automatic out_chk(input string tag);
    check({tag, " R4 pin_oe"},   {26'd0, pin_oe},   mdl[1]);
    check({tag, " R5 pin_out"},  {26'd0, pin_out},  mdl[2]);
    check({tag, " R6 irq_en"},   {26'd0, irq_en},   mdl[3]);
    check({tag, " R7 irq_pol"},  {26'd0, irq_pol},  mdl[7]);
    check({tag, " R7 irq_type"}, {26'd0, irq_type}, mdl[8]);
    check({tag, " R8 irq_stat"}, {26'd0, irq_stat}, mdl[9]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] q; logic v;
    for (int f = 0; f < 10; f++) mdl[f] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid in reset", {95'd0, rsp_valid}, 96'd0);
    rst_n = 1'b1;
    @(negedge clk);
    out_chk("R1 after reset");
    for (int f = 1; f < 10; f++) rd_chk(12'(B[f]), "R1 reset");

    // R3 layout: pin 37 is bit 5 of word 1 of the direction bank
    wr_chk(12'h018, 32'h0000_0020, "R3");
    check("R3 pin37 oe", {95'd0, pin_oe[37]}, 96'd1);
    check("R3 only pin37", {26'd0, pin_oe}, {26'd0, 70'd1 << 37});
    wr_chk(12'h018, 32'd0, "R3");

    // R9 upper pins: word 2 keeps only bits 0..5
    wr_chk(12'h11C, 32'hffff_ffff, "R9");
    rd_chk(12'h11C, "R9 type word2");
    check("R9 type pin69", {95'd0, irq_type[69]}, 96'd1);

    // R10 unmapped addresses read zero and leave state alone
    wr_chk(12'h000, 32'hffff_ffff, "R10");
    wr_chk(12'h004, 32'hffff_ffff, "R10");
    wr_chk(12'h050, 32'hffff_ffff, "R10");
    wr_chk(12'h015, 32'hffff_ffff, "R10");
    rd_chk(12'h050, "R10 gap");
    rd_chk(12'h016, "R10 unaligned");
    out_chk("R10 no effect");

    // R6 groups 1..3 do not reach irq_en
    wr_chk(12'h054, 32'hdead_beef, "R6");
    wr_chk(12'h074, 32'h1234_5678, "R6");
    rd_chk(12'h054, "R6 grp1"); rd_chk(12'h074, "R6 grp3");
    check("R6 irq_en untouched", {26'd0, irq_en}, 96'd0);
    wr_chk(12'h048, 32'h0000_00ff, "R6");
    out_chk("R6 grp0");

    // R11 synchronizer depth
    @(negedge clk); pin_in = 70'h2A_5555_AAAA_0F0F_F0F0;
    @(negedge clk); check("R11 one edge", {26'd0, pin_sync}, 96'd0);
    @(negedge clk); check("R11 two edges", {26'd0, pin_sync}, {26'd0, pin_in});
    // R5 read returns pin levels, not written values
    wr_chk(12'h024, 32'hcafe_f00d, "R5");
    rd_chk(12'h024, "R5 level w0"); rd_chk(12'h02C, "R5 level w2");
    out_chk("R5");

    // R8 set, W1C, write 0, set beats clear
    @(negedge clk); irq_stat_set = (70'd1 << 5) | (70'd1 << 6) | (70'd1 << 40);
    @(negedge clk); irq_stat_set = '0;
    mdl[9] = {26'd0, (70'd1 << 5) | (70'd1 << 6) | (70'd1 << 40)};
    out_chk("R8 set");
    wr_chk(12'h124, 32'd0, "R8 write0");
    rd_chk(12'h124, "R8 after w0");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h124; req_wdata = 32'h0000_0060;
    irq_stat_set = 70'd1 << 5;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; irq_stat_set = '0;
    mdl[9] = {26'd0, (70'd1 << 5) | (70'd1 << 40)};
    check("R8 set beats clear", {26'd0, irq_stat}, mdl[9]);
    wr_chk(12'h128, 32'h0000_0100, "R8 w1c");
    rd_chk(12'h128, "R8 word1");

    // random mix of reads and writes
    for (int i = 0; i < 400; i++) begin
      int f = 1 + int'($urandom % 9);
      int w = int'($urandom % 3);
      int k = int'($urandom % 8);
      logic [11:0] a;
      if (k == 0)      a = 12'($urandom);
      else if (k == 1) a = 12'(B[f] + 12);
      else             a = 12'(B[f] + 4 * w);
      if (i % 25 == 0) begin
        @(negedge clk); pin_in = {6'($urandom), $urandom, $urandom};
        repeat (2) @(negedge clk);
      end
      if ($urandom % 2 == 0) wr_chk(a, $urandom, "R3 random");
      else                   rd_chk(a, "R3 random");
      if (i % 20 == 0) out_chk("R3 random");
    end
    out_chk("final");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule